// File: doc/BRIEF.md
# Interval-Bucket Event Drain with Staleness Filter

This block is the streaming half of a two-level event calendar. Events that lie far in the future are written, unsorted, into one of several buckets. Each bucket stands for one fixed slice of simulated time. The bucket is picked from a shifted field of the event's time tag, taken modulo the bucket count, and each new event goes at the end of that bucket's fill.

When the near-term queue needs more work, a drain request streams the next bucket in round-robin order out of its storage. This block does not remove cancelled events by chasing pointers. Instead it keeps, for every particle, the time of that particle's most recent invalidation. Each streamed event carries the time at which it was queued. The event is dropped if that time is earlier than the last invalidation of either of its two particles.

Events that survive are placed into a small buffer by insertion sort, one per cycle. The sorted contents are then emitted as a stream, soonest time first. The stream flags its final entry and ends with a completion pulse. Bucket storage is modelled as on-chip RAM with one write port and one read port.

Top module: `evcal_bucket_drain`

## Requirements
- R1: After synchronous reset, `busy`, `out_valid`, `out_last`, `drain_done` and `app_err` are 0, and the first drain reads bucket 0.
- R2: An appended event goes into bucket `app_time[SHIFT+BKT_W-1:SHIFT]`, which is bits [5:4] with the defaults. Higher time bits are ignored, so times 16 apart per step wrap around the buckets. Successive drains visit buckets 0, 1, 2, 3, 0, and so on.
- R3: A drain emits the kept events of its bucket in nondecreasing `out_time`. Events with equal times come out in the order they were appended.
- R4: A streamed event is dropped if its queued stamp is strictly less than the recorded invalidation time of its first or its second particle. A stamp equal to that time is kept.
- R5: An invalidation record writes the time for one particle, replacing any earlier value. The table is 0 after reset.
- R6: An append to a bucket that already holds `BKT_DEPTH` events is not stored. `app_err` is 1 in the cycle after it, and the bucket's contents stay unchanged.
- R7: An append aimed at the bucket under drain is rejected with `app_err`. This includes an append in the same cycle the drain is accepted. An append to any other bucket during a drain is accepted.
- R8: Emitted entries come on consecutive cycles, and `out_last` marks only the final one. `drain_done` pulses for one cycle, one cycle after that final entry. A drain with no surviving events pulses `drain_done` without any `out_valid`.
- R9: A drain request while `busy` is ignored. A drained bucket is left empty for its next turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_valid | input | 1 | Append an event this cycle |
| app_time | input | TIME_W | Event time tag; selects the bucket |
| app_pa | input | PART_W | First particle of the event |
| app_pb | input | PART_W | Second particle of the event |
| app_stamp | input | TIME_W | Time at which the event was queued |
| app_err | output | 1 | Previous append was rejected (bucket full or under drain) |
| inv_valid | input | 1 | Write an invalidation record |
| inv_part | input | PART_W | Particle being invalidated |
| inv_time | input | TIME_W | Invalidation time for that particle |
| drain_req | input | 1 | Start draining the next bucket |
| busy | output | 1 | A drain is in progress |
| out_valid | output | 1 | Sorted output entry valid |
| out_time | output | TIME_W | Time tag of the output entry |
| out_pa | output | PART_W | First particle of the output entry |
| out_pb | output | PART_W | Second particle of the output entry |
| out_stamp | output | TIME_W | Queued stamp of the output entry |
| out_last | output | 1 | Final entry of this drain |
| drain_done | output | 1 | One-cycle pulse ending a drain |

## Verification
The bench goes after equal time tags appended out of order. An unstable insertion would swap them and break the recorded particle order. It also tests stamps exactly equal to an invalidation time, which a design using the wrong comparison would drop, and staleness arising from either particle alone, which a design checking only one particle would pass through.

A ninth append to a full bucket and an append to the bucket under drain both must raise the error and leave the stored events intact. A wrong full test would overwrite slot zero and corrupt the later drain.

A drain request held for two cycles must not skip a bucket, and a re-drained bucket must come back empty. A design that double-advances its bucket pointer, or forgets to clear the fill count, would emit the wrong events there.

// File: rtl/evcal_pkg.sv
package evcal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EMIT  = 2'd2
  } drain_state_t;
endpackage

// File: rtl/evcal_bkt_ram.sv
// Simple dual-port storage for all buckets: one write port, one registered read port.
module evcal_bkt_ram #(
  parameter int AW = 5,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/evcal_stale_filt.sv
// Per-particle last-invalidation table and the keep/drop decision for a streamed event.
module evcal_stale_filt #(
  parameter int TIME_W = 16,
  parameter int PART_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_valid,
  input  logic [PART_W-1:0] inv_part,
  input  logic [TIME_W-1:0] inv_time,
  input  logic [PART_W-1:0] ev_pa,
  input  logic [PART_W-1:0] ev_pb,
  input  logic [TIME_W-1:0] ev_stamp,
  output logic              keep
);
  localparam int NUM_PART = 1 << PART_W;

  logic [TIME_W-1:0] inv_tab [NUM_PART];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PART; i++) inv_tab[i] <= '0;
    end else if (inv_valid) begin
      inv_tab[inv_part] <= inv_time;
    end
  end

  always_comb begin
    keep = !((ev_stamp < inv_tab[ev_pa]) || (ev_stamp < inv_tab[ev_pb]));
  end
endmodule

// File: rtl/evcal_sort_buf.sv
// Insertion-sort buffer: one insert or one pop per cycle, stable for equal keys.
module evcal_sort_buf #(
  parameter int EV_W  = 40,
  parameter int KEY_W = 16,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            ins_en,
  input  logic [EV_W-1:0] ins_data,
  input  logic            pop,
  output logic [EV_W-1:0] head_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [EV_W-1:0]  ent [DEPTH];
  logic [CNT_W-1:0] pos;
  logic [KEY_W-1:0] ins_key;

  assign ins_key   = ins_data[EV_W-1 -: KEY_W];
  assign head_data = ent[0];

  // Slot for the new entry: after every held entry whose key is not larger.
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && (ent[i][EV_W-1 -: KEY_W] <= ins_key))
        pos = pos + 1'b1;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ins_en) begin
        if (CNT_W'(gi) == pos) begin
          ent[gi] <= ins_data;
        end else if (CNT_W'(gi) > pos) begin
          if (gi > 0) ent[gi] <= ent[(gi > 0) ? gi - 1 : 0];
        end
      end else if (pop) begin
        if (gi < DEPTH - 1) ent[gi] <= ent[(gi < DEPTH - 1) ? gi + 1 : gi];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (ins_en) begin
      count <= count + 1'b1;
    end else if (pop && (count != '0)) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/evcal_bucket_drain.sv
module evcal_bucket_drain #(
  parameter int TIME_W    = 16,
  parameter int PART_W    = 4,
  parameter int NUM_BKT   = 4,
  parameter int BKT_DEPTH = 8,
  parameter int SHIFT     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              app_valid,
  input  logic [TIME_W-1:0] app_time,
  input  logic [PART_W-1:0] app_pa,
  input  logic [PART_W-1:0] app_pb,
  input  logic [TIME_W-1:0] app_stamp,
  output logic              app_err,
  input  logic              inv_valid,
  input  logic [PART_W-1:0] inv_part,
  input  logic [TIME_W-1:0] inv_time,
  input  logic              drain_req,
  output logic              busy,
  output logic              out_valid,
  output logic [TIME_W-1:0] out_time,
  output logic [PART_W-1:0] out_pa,
  output logic [PART_W-1:0] out_pb,
  output logic [TIME_W-1:0] out_stamp,
  output logic              out_last,
  output logic              drain_done
);
  import evcal_pkg::*;

  localparam int BKT_W  = $clog2(NUM_BKT);
  localparam int SLOT_W = $clog2(BKT_DEPTH);
  localparam int CNT_W  = SLOT_W + 1;
  localparam int ADDR_W = BKT_W + SLOT_W;
  localparam int EV_W   = 2 * TIME_W + 2 * PART_W;
  localparam int SB_W   = $clog2(BKT_DEPTH + 1);

  drain_state_t      state;
  logic [BKT_W-1:0]  head;
  logic [CNT_W-1:0]  bkt_cnt [NUM_BKT];
  logic [CNT_W-1:0]  snap_cnt;
  logic [CNT_W-1:0]  rd_idx;
  logic              rd_vld;

  // Append path
  logic [BKT_W-1:0]  app_bkt;
  logic              drain_start;
  logic              app_full;
  logic              app_block;
  logic              app_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [EV_W-1:0]   wr_data;

  assign app_bkt     = app_time[SHIFT +: BKT_W];
  assign drain_start = (state == ST_IDLE) && drain_req;
  assign app_full    = (bkt_cnt[app_bkt] == CNT_W'(BKT_DEPTH));
  assign app_block   = ((state != ST_IDLE) || drain_start) && (app_bkt == head);
  assign app_ok      = app_valid && !app_full && !app_block;
  assign wr_addr     = {app_bkt, bkt_cnt[app_bkt][SLOT_W-1:0]};
  assign wr_data     = {app_time, app_pa, app_pb, app_stamp};

  for (genvar gb = 0; gb < NUM_BKT; gb++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        bkt_cnt[gb] <= '0;
      end else if (drain_start && (head == BKT_W'(gb))) begin
        bkt_cnt[gb] <= '0;
      end else if (app_ok && (app_bkt == BKT_W'(gb))) begin
        bkt_cnt[gb] <= bkt_cnt[gb] + 1'b1;
      end
    end
  end

  // Stream path
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [EV_W-1:0]   rd_q;

  assign rd_en   = (state == ST_FETCH) && (rd_idx < snap_cnt);
  assign rd_addr = {head, rd_idx[SLOT_W-1:0]};

  evcal_bkt_ram #(.AW(ADDR_W), .DW(EV_W)) u_ram (
    .clk   (clk),
    .we    (app_ok),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_q)
  );

  logic [PART_W-1:0] rd_pa, rd_pb;
  logic [TIME_W-1:0] rd_stamp;
  logic              keep;

  assign rd_pa    = rd_q[TIME_W + 2*PART_W - 1 -: PART_W];
  assign rd_pb    = rd_q[TIME_W + PART_W - 1 -: PART_W];
  assign rd_stamp = rd_q[TIME_W-1:0];

  evcal_stale_filt #(.TIME_W(TIME_W), .PART_W(PART_W)) u_filt (
    .clk       (clk),
    .rst       (rst),
    .inv_valid (inv_valid),
    .inv_part  (inv_part),
    .inv_time  (inv_time),
    .ev_pa     (rd_pa),
    .ev_pb     (rd_pb),
    .ev_stamp  (rd_stamp),
    .keep      (keep)
  );

  logic            sb_pop;
  logic [EV_W-1:0] sb_head;
  logic [SB_W-1:0] sb_cnt;

  assign sb_pop = (state == ST_EMIT) && (sb_cnt != '0);

  evcal_sort_buf #(.EV_W(EV_W), .KEY_W(TIME_W), .DEPTH(BKT_DEPTH)) u_sort (
    .clk       (clk),
    .rst       (rst),
    .clr       (drain_start),
    .ins_en    (rd_vld && keep),
    .ins_data  (rd_q),
    .pop       (sb_pop),
    .head_data (sb_head),
    .count     (sb_cnt)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      head       <= '0;
      snap_cnt   <= '0;
      rd_idx     <= '0;
      rd_vld     <= 1'b0;
      app_err    <= 1'b0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      out_time   <= '0;
      out_pa     <= '0;
      out_pb     <= '0;
      out_stamp  <= '0;
      drain_done <= 1'b0;
    end else begin
      app_err    <= app_valid && !app_ok;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      drain_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (drain_req) begin
            snap_cnt <= bkt_cnt[head];
            rd_idx   <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          rd_vld <= (rd_idx < snap_cnt);
          if (rd_idx < snap_cnt) rd_idx <= rd_idx + 1'b1;
          else state <= ST_EMIT;
        end
        ST_EMIT: begin
          if (sb_cnt != '0) begin
            out_valid <= 1'b1;
            out_last  <= (sb_cnt == SB_W'(1));
            out_time  <= sb_head[EV_W-1 -: TIME_W];
            out_pa    <= sb_head[TIME_W + 2*PART_W - 1 -: PART_W];
            out_pb    <= sb_head[TIME_W + PART_W - 1 -: PART_W];
            out_stamp <= sb_head[TIME_W-1:0];
          end else begin
            drain_done <= 1'b1;
            head       <= (head == BKT_W'(NUM_BKT - 1)) ? '0 : head + 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evcal_bucket_drain_chk.sv
module evcal_bucket_drain_chk #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              app_valid,
  input logic              app_err,
  input logic              busy,
  input logic              out_valid,
  input logic              out_last,
  input logic [TIME_W-1:0] out_time,
  input logic              drain_done
);
  // R6/R7: an error flag only ever follows an append attempt
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    app_err |-> $past(app_valid));

  // R3: within one drain, times never decrease
  assert_sorted_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && !$past(out_last)) |-> (out_time >= $past(out_time)));

  // R8: the final entry is followed by the done pulse and no more output
  assert_last_done_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> (drain_done && !out_valid));

  // R8: done is a single-cycle pulse and never overlaps output
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> (!out_valid && !$past(drain_done)));

  // R9: output only appears during a drain
  assert_out_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  // R8: done only ends a drain that was running
  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> $past(busy));
endmodule

bind evcal_bucket_drain evcal_bucket_drain_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .app_valid  (app_valid),
  .app_err    (app_err),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_time   (out_time),
  .drain_done (drain_done)
);

// File: tb/evcal_bucket_drain_tb.sv
module evcal_bucket_drain_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        app_valid = 1'b0;
  logic [15:0] app_time = '0;
  logic [3:0]  app_pa = '0;
  logic [3:0]  app_pb = '0;
  logic [15:0] app_stamp = '0;
  logic        app_err;
  logic        inv_valid = 1'b0;
  logic [3:0]  inv_part = '0;
  logic [15:0] inv_time = '0;
  logic        drain_req = 1'b0;
  logic        busy, out_valid, out_last, drain_done;
  logic [15:0] out_time, out_stamp;
  logic [3:0]  out_pa, out_pb;

  always #10 clk = ~clk;

  evcal_bucket_drain u_dut (
    .clk(clk), .rst(rst),
    .app_valid(app_valid), .app_time(app_time), .app_pa(app_pa), .app_pb(app_pb),
    .app_stamp(app_stamp), .app_err(app_err),
    .inv_valid(inv_valid), .inv_part(inv_part), .inv_time(inv_time),
    .drain_req(drain_req), .busy(busy),
    .out_valid(out_valid), .out_time(out_time), .out_pa(out_pa), .out_pb(out_pb),
    .out_stamp(out_stamp), .out_last(out_last), .drain_done(drain_done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int got_n = 0;
  int done_cnt = 0;
  logic [15:0] got_t [64];
  logic [3:0]  got_pa [64];
  logic        got_last [64];

  // Output collector, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && out_valid && got_n < 64) begin
      got_t[got_n]    = out_time;
      got_pa[got_n]   = out_pa;
      got_last[got_n] = out_last;
      got_n++;
    end
    if (!rst && drain_done) done_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic app(input logic [15:0] t, input logic [3:0] pa, input logic [3:0] pb,
                     input logic [15:0] st, input int exp_err, input string tag);
    app_valid = 1'b1; app_time = t; app_pa = pa; app_pb = pb; app_stamp = st;
    @(negedge clk);
    app_valid = 1'b0;
    chk(tag, app_err, exp_err);
  endtask

  task automatic inv(input logic [3:0] p, input logic [15:0] t);
    inv_valid = 1'b1; inv_part = p; inv_time = t;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int k = 0; k < 200 && done_cnt == d0; k++) @(negedge clk);
  endtask

  task automatic check_out(input int base, input int n, input logic [15:0] et [8],
                           input logic [3:0] ea [8], input string tag);
    chk({tag, " count"}, got_n - base, n);
    for (int k = 0; k < n && k < got_n - base; k++) begin
      chk({tag, " time"}, got_t[base+k], et[k]);
      chk({tag, " pa"}, got_pa[base+k], ea[k]);
      chk({tag, " last"}, got_last[base+k], (k == n - 1) ? 1 : 0);
    end
  endtask

  task automatic do_drain(input int n, input logic [15:0] et [8],
                          input logic [3:0] ea [8], input string tag);
    int base = got_n;
    int d0 = done_cnt;
    drain_req = 1'b1;
    @(negedge clk);
    drain_req = 1'b0;
    wait_done(d0);
    chk({tag, " done"}, done_cnt - d0, 1);
    check_out(base, n, et, ea, tag);
    @(negedge clk);
    chk({tag, " done pulse"}, drain_done, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 out_last", out_last, 0);
    chk("R1 drain_done", drain_done, 0);
    chk("R1 app_err", app_err, 0);
  endtask

  // R3 sort with equal times, R2 wrap of high time bits, R1 first drain is bucket 0
  task automatic t_sort();
    app(16'h000C, 4'd1, 4'd9, 16'd10, 0, "R2 app");
    app(16'h0003, 4'd2, 4'd9, 16'd10, 0, "R2 app");
    app(16'h0040, 4'd3, 4'd9, 16'd10, 0, "R2 app");
    app(16'h0003, 4'd4, 4'd9, 16'd10, 0, "R2 app");
    app(16'h0008, 4'd5, 4'd9, 16'd10, 0, "R2 app");
    do_drain(5, '{16'h03, 16'h03, 16'h08, 16'h0C, 16'h40, 0, 0, 0},
                '{4'd2, 4'd4, 4'd5, 4'd1, 4'd3, 0, 0, 0}, "R3 sort");
  endtask

  // R2 bucket selection from bits [5:4] and round-robin order
  task automatic t_select();
    app(16'h0015, 4'd1, 4'd9, 16'd0, 0, "R2 app");
    app(16'h0025, 4'd2, 4'd9, 16'd0, 0, "R2 app");
    app(16'h0011, 4'd3, 4'd9, 16'd0, 0, "R2 app");
    app(16'h009A, 4'd4, 4'd9, 16'd0, 0, "R2 app");
    do_drain(3, '{16'h11, 16'h15, 16'h9A, 0, 0, 0, 0, 0},
                '{4'd3, 4'd1, 4'd4, 0, 0, 0, 0, 0}, "R2 bucket1");
    do_drain(1, '{16'h25, 0, 0, 0, 0, 0, 0, 0},
                '{4'd2, 0, 0, 0, 0, 0, 0, 0}, "R2 bucket2");
  endtask

  // R4 staleness on either particle, equal stamp kept; R5 overwrite of a record
  task automatic t_stale();
    inv(4'd5, 16'd100);
    inv(4'd6, 16'd50);
    inv(4'd7, 16'd200);
    inv(4'd7, 16'd30);
    app(16'h0031, 4'd5, 4'd1, 16'd99,  0, "R4 app");
    app(16'h0032, 4'd1, 4'd6, 16'd49,  0, "R4 app");
    app(16'h0033, 4'd5, 4'd6, 16'd100, 0, "R4 app");
    app(16'h0034, 4'd2, 4'd3, 16'd0,   0, "R4 app");
    app(16'h0035, 4'd7, 4'd1, 16'd40,  0, "R5 app");
    do_drain(3, '{16'h33, 16'h34, 16'h35, 0, 0, 0, 0, 0},
                '{4'd5, 4'd2, 4'd7, 0, 0, 0, 0, 0}, "R4 R5 stale");
  endtask

  // R6 full bucket rejected, contents kept; R8 empty drain
  task automatic t_full();
    for (int i = 7; i >= 0; i--)
      app(16'(16'h41 * i), 4'(i), 4'd9, 16'd300, 0, "R6 fill");
    app(16'h0200, 4'd15, 4'd9, 16'd300, 1, "R6 full err");
    do_drain(8, '{16'h000, 16'h041, 16'h082, 16'h0C3, 16'h104, 16'h145, 16'h186, 16'h1C7},
                '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7}, "R6 kept");
    do_drain(0, '{0, 0, 0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0}, "R8 empty");
  endtask

  // R7 append to bucket under drain; R9 held request ignored, drained bucket left empty
  task automatic t_conflict();
    int base;
    int d0;
    app(16'h0020, 4'd1, 4'd9, 16'd400, 0, "R7 app");
    base = got_n;
    d0 = done_cnt;
    drain_req = 1'b1;
    @(negedge clk);
    app_valid = 1'b1; app_time = 16'h0021; app_pa = 4'd2; app_pb = 4'd9; app_stamp = 16'd400;
    @(negedge clk);
    drain_req = 1'b0;
    chk("R7 reject draining bucket", app_err, 1);
    app_time = 16'h0030; app_pa = 4'd3;
    @(negedge clk);
    app_valid = 1'b0;
    chk("R7 other bucket accepted", app_err, 0);
    wait_done(d0);
    chk("R7 done", done_cnt - d0, 1);
    check_out(base, 1, '{16'h20, 0, 0, 0, 0, 0, 0, 0}, '{4'd1, 0, 0, 0, 0, 0, 0, 0}, "R7 drain");
    @(negedge clk);
    do_drain(1, '{16'h30, 0, 0, 0, 0, 0, 0, 0}, '{4'd3, 0, 0, 0, 0, 0, 0, 0}, "R9 no skip");
    do_drain(0, '{0, 0, 0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0, 0, 0}, "R9 emptied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sort();
    t_select();
    t_stale();
    t_full();
    t_conflict();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule